// File: doc/BRIEF.md
# Serial Controller Configuration Guard

This block is the register front end of a serial-peripheral controller. It sits on an APB bus and holds the controller's configuration: a mode register, one configuration register for each chip select, and an interrupt mask that is set and cleared through separate write ports. A protection switch can lock the mode and chip-select registers. While the lock is on, writes to them are dropped without a bus error. Every event that software may need to know about is recorded in a read-only status word.

The status word has three independent sticky flags. The first records a dropped write. The second records a software reset issued while the lock was on. The third records a reconfiguration write that landed while the chip select it affects was in use. A second field holds the bus offset of the register involved in the most recent dropped or in-use write. Reading the status word returns everything gathered since the previous read and then empties it. Chip-select activity arrives from the shifting engine as a plain input vector. The engine itself is not part of this block.

Top module: `spi_cfg_guard`

## Requirements
- R1: After reset, the mode register, every chip-select register, the interrupt mask, the lock bit and the whole status word all read as zero.
- R2: While the lock (offset 0x1C, bit 0) is set, a write to the mode register (0x04) or to chip-select register i (0x40 + 4*i) leaves that register unchanged and keeps pslverr at 0. It also sets status bit 0 and loads status bits [23:8] with the written offset.
- R3: While the lock is clear, writes to the mode and chip-select registers take effect and read back. The lock bit and the interrupt enable and disable ports stay writable whether or not the lock is set.
- R4: A write to the mode register while any bit of csActive is high sets status bit 2 and loads the source field with 0x04. With the lock clear, the write still takes effect.
- R5: A write to chip-select register i while csActive[i] is high sets status bit 2 and loads the source field with that register's offset. The same write made while only other chip selects are active sets no flag.
- R6: A write of 1 in bit 0 at offset 0x00 is a software reset. It clears the mode, chip-select and mask registers. If the lock is set at that moment, the reset also sets status bit 1 and leaves the source field unchanged. With the lock clear, it sets no flag.
- R7: Status bit 1 is also cleared by any write to the mode register, to a chip-select register, or to the interrupt enable (0x10) or disable (0x14) port, including writes that are dropped. Bits 0 and 2 are not cleared by these writes.
- R8: A read of the status word (0x20) returns the flags in bits [2:0] and the source in bits [23:8], with all other bits zero. Flags gather as a bitwise OR between reads, and a read clears both the flags and the source.
- R9: A write to the status word does not change its contents.
- R10: A write to 0x10 sets the mask bits that are 1 in the data. A write to 0x14 clears them. The mask reads back at 0x18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable, marks the access phase |
| pwrite | input | 1 | APB write when high, read when low |
| paddr | input | 8 | APB byte offset |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid in the access phase |
| pready | output | 1 | Always high: no wait states |
| pslverr | output | 1 | Always low: dropped writes raise no error |
| csActive | input | 4 | Chip selects currently in use by the engine |
| modeOut | output | 8 | Current mode configuration |
| csCfgOut | output | 64 | Chip-select configurations, register i in bits [16*i+15:16*i] |
| intMaskOut | output | 4 | Current interrupt mask |

## Verification
The assertions assume well-formed APB traffic. Each access has a setup cycle followed by exactly one access cycle, and address, direction and data do not change across the two. As a result, a status read and a write never share a cycle, so no check has to settle a clear and a new event at the same edge. The assertions also assume that csActive does not change during an access phase. The stimulus keeps within these limits: all transfers come from one task that produces setup and access phases in order, and the chip-select vector is changed only while the bus is idle.

// File: rtl/spi_cfg_guard_pkg.sv
package spi_cfg_guard_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int NUM_CS = 4;
  localparam int CS_IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
  localparam int SRC_W = 16;

  localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_MODE  = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_IEN   = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_IDIS  = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_IMASK = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_LOCK  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_CS    = 8'h40;
  localparam logic [ADDR_W-1:0] CS_SPAN   = ADDR_W'(4 * NUM_CS);

  typedef enum logic [2:0] {
    RD_NONE, RD_MODE, RD_CS, RD_IMASK, RD_LOCK, RD_STAT
  } rdSel_e;

  typedef struct packed {
    logic                wrMode;
    logic                wrCs;
    logic [CS_IDX_W-1:0] csIdx;
    logic                wrIen;
    logic                wrIdis;
    logic                wrLock;
    logic                swReset;
    logic                swViol;
    logic                rdStat;
    logic                blockedHit;
    logic                inUseHit;
    logic                clrSwFlag;
    logic [SRC_W-1:0]    srcOff;
    rdSel_e              rdSel;
  } strobes_t;
endpackage

// File: rtl/spi_cfg_guard_ctrl.sv
module spi_cfg_guard_ctrl
  import spi_cfg_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic              pwdata0,
  input  logic [NUM_CS-1:0] csActive,
  input  logic              lockOn,
  output strobes_t          stb
);
  logic              access;
  logic              wrAcc;
  logic [ADDR_W-1:0] csRel;
  logic              isCs;
  logic              isMode;
  logic              protTarget;
  logic              csBusy;

  assign access = psel && penable;
  assign wrAcc  = access && pwrite;
  assign csRel  = paddr - OFF_CS;
  assign isCs   = (csRel[1:0] == 2'b00) && (csRel < CS_SPAN);
  assign isMode = (paddr == OFF_MODE);
  assign protTarget = wrAcc && (isMode || isCs);

  always_comb begin
    csBusy = 1'b0;
    if (isMode) csBusy = |csActive;
    else if (isCs) csBusy = csActive[csRel[2 +: CS_IDX_W]];
  end

  always_comb begin
    stb = '0;
    stb.csIdx      = csRel[2 +: CS_IDX_W];
    stb.srcOff     = {{(SRC_W-ADDR_W){1'b0}}, paddr};
    stb.wrMode     = wrAcc && isMode && !lockOn;
    stb.wrCs       = wrAcc && isCs && !lockOn;
    stb.wrIen      = wrAcc && (paddr == OFF_IEN);
    stb.wrIdis     = wrAcc && (paddr == OFF_IDIS);
    stb.wrLock     = wrAcc && (paddr == OFF_LOCK);
    stb.swReset    = wrAcc && (paddr == OFF_CTRL) && pwdata0;
    stb.swViol     = stb.swReset && lockOn;
    stb.rdStat     = access && !pwrite && (paddr == OFF_STAT);
    stb.blockedHit = protTarget && lockOn;
    stb.inUseHit   = protTarget && csBusy;
    stb.clrSwFlag  = protTarget || stb.wrIen || stb.wrIdis;
    if (isCs) stb.rdSel = RD_CS;
    else begin
      case (paddr)
        OFF_MODE:  stb.rdSel = RD_MODE;
        OFF_IMASK: stb.rdSel = RD_IMASK;
        OFF_LOCK:  stb.rdSel = RD_LOCK;
        OFF_STAT:  stb.rdSel = RD_STAT;
        default:   stb.rdSel = RD_NONE;
      endcase
    end
  end

  AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrMode, stb.wrCs, stb.wrIen, stb.wrIdis, stb.wrLock, stb.swReset})); // R3

  AST_READ_NOT_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdStat |-> !(stb.blockedHit || stb.inUseHit || stb.swViol || stb.clrSwFlag)); // R8
endmodule

// File: rtl/spi_cfg_guard_regs.sv
module spi_cfg_guard_regs
  import spi_cfg_guard_pkg::*;
#(
  parameter int MODE_W = 8,
  parameter int CS_W   = 16,
  parameter int INT_W  = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobes_t               stb,
  input  logic [DATA_W-1:0]      pwdata,
  output logic                   lockOn,
  output logic [DATA_W-1:0]      prdata,
  output logic [MODE_W-1:0]      modeOut,
  output logic [NUM_CS*CS_W-1:0] csCfgOut,
  output logic [INT_W-1:0]       intMaskOut
);
  localparam int USE_W = (CS_W > MODE_W) ? ((CS_W > INT_W) ? CS_W : INT_W)
                                         : ((MODE_W > INT_W) ? MODE_W : INT_W);

  logic [MODE_W-1:0] modeReg;
  logic [CS_W-1:0]   csReg [NUM_CS];
  logic [INT_W-1:0]  maskReg;
  logic              lockReg;
  logic [2:0]        vFlags;
  logic [SRC_W-1:0]  vSrc;
  logic              unusedHi;

  assign unusedHi = ^pwdata[DATA_W-1:USE_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= '0;
      maskReg <= '0;
      lockReg <= 1'b0;
      vFlags  <= '0;
      vSrc    <= '0;
      for (int i = 0; i < NUM_CS; i++) csReg[i] <= '0;
    end else begin
      if (stb.swReset) begin
        modeReg <= '0;
        maskReg <= '0;
        for (int i = 0; i < NUM_CS; i++) csReg[i] <= '0;
      end else begin
        if (stb.wrMode) modeReg <= pwdata[MODE_W-1:0];
        if (stb.wrCs) csReg[stb.csIdx] <= pwdata[CS_W-1:0];
        if (stb.wrIen) maskReg <= maskReg | pwdata[INT_W-1:0];
        if (stb.wrIdis) maskReg <= maskReg & ~pwdata[INT_W-1:0];
      end
      if (stb.wrLock) lockReg <= pwdata[0];
      vFlags[0] <= (vFlags[0] && !stb.rdStat) || stb.blockedHit;
      vFlags[1] <= (vFlags[1] && !(stb.rdStat || stb.clrSwFlag)) || stb.swViol;
      vFlags[2] <= (vFlags[2] && !stb.rdStat) || stb.inUseHit;
      if (stb.blockedHit || stb.inUseHit) vSrc <= stb.srcOff;
      else if (stb.rdStat) vSrc <= '0;
    end
  end

  generate
    for (genvar g = 0; g < NUM_CS; g++) begin : g_csOut
      assign csCfgOut[g*CS_W +: CS_W] = csReg[g];
    end
  endgenerate

  assign modeOut    = modeReg;
  assign intMaskOut = maskReg;
  assign lockOn     = lockReg;

  always_comb begin
    prdata = '0;
    case (stb.rdSel)
      RD_MODE:  prdata[MODE_W-1:0] = modeReg;
      RD_CS:    prdata[CS_W-1:0] = csReg[stb.csIdx];
      RD_IMASK: prdata[INT_W-1:0] = maskReg;
      RD_LOCK:  prdata[0] = lockReg;
      RD_STAT: begin
        prdata[2:0] = vFlags;
        prdata[8 +: SRC_W] = vSrc;
      end
      default:  prdata = '0;
    endcase
  end

  AST_BLOCK_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rstN)
    stb.blockedHit |=> $stable(modeOut) && $stable(csCfgOut)); // R2

  AST_BLOCK_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    stb.blockedHit |=> vFlags[0] && (vSrc == $past(stb.srcOff))); // R2

  AST_INUSE_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    stb.inUseHit |=> vFlags[2] && (vSrc == $past(stb.srcOff))); // R4

  AST_SWRESET_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    stb.swViol |=> vFlags[1] && (modeOut == '0) && (intMaskOut == '0)); // R6

  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdStat |=> (vFlags == 3'b000) && (vSrc == '0)); // R8

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdStat |=> ((vFlags & $past(vFlags) & 3'b101) == ($past(vFlags) & 3'b101))); // R7
endmodule

// File: rtl/spi_cfg_guard.sv
module spi_cfg_guard
  import spi_cfg_guard_pkg::*;
#(
  parameter int MODE_W = 8,
  parameter int CS_W   = 16,
  parameter int INT_W  = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   psel,
  input  logic                   penable,
  input  logic                   pwrite,
  input  logic [ADDR_W-1:0]      paddr,
  input  logic [DATA_W-1:0]      pwdata,
  output logic [DATA_W-1:0]      prdata,
  output logic                   pready,
  output logic                   pslverr,
  input  logic [NUM_CS-1:0]      csActive,
  output logic [MODE_W-1:0]      modeOut,
  output logic [NUM_CS*CS_W-1:0] csCfgOut,
  output logic [INT_W-1:0]       intMaskOut
);
  strobes_t stb;
  logic     lockOn;

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  spi_cfg_guard_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .pwdata0  (pwdata[0]),
    .csActive (csActive),
    .lockOn   (lockOn),
    .stb      (stb)
  );

  spi_cfg_guard_regs #(
    .MODE_W (MODE_W),
    .CS_W   (CS_W),
    .INT_W  (INT_W)
  ) regs_i (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .pwdata     (pwdata),
    .lockOn     (lockOn),
    .prdata     (prdata),
    .modeOut    (modeOut),
    .csCfgOut   (csCfgOut),
    .intMaskOut (intMaskOut)
  );
endmodule

// File: tb/spi_cfg_guard_tb_top.sv
module spi_cfg_guard_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        psel = 1'b0;
  logic        penable = 1'b0;
  logic        pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  logic        pslverr;
  logic [3:0]  csActive = '0;
  logic [7:0]  modeOut;
  logic [63:0] csCfgOut;
  logic [3:0]  intMaskOut;

  int  checks = 0;
  int  failures = 0;
  bit  finished = 1'b0;

  typedef struct {
    bit          isRd;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];

  always #2 clk = ~clk;

  spi_cfg_guard dut_i (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .csActive(csActive), .modeOut(modeOut),
    .csCfgOut(csCfgOut), .intMaskOut(intMaskOut)
  );

  task automatic xfer(input bit wr, input logic [7:0] a, input logic [31:0] d,
                      input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    @(posedge clk); #1;
    penable = 1'b1;
    it.isRd = !wr; it.exp = e; it.tag = tag;
    sbq.push_back(it);
    @(posedge clk); #1;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    xfer(1'b1, a, d, 32'h0, tag);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    xfer(1'b0, a, 32'h0, e, tag);
  endtask

  task automatic setCs(input logic [3:0] v);
    @(posedge clk); #1;
    csActive = v;
  endtask

  always @(negedge clk) begin
    if (psel && penable) begin
      item_t it;
      if (sbq.size() == 0) begin
        failures++;
        $display("FAIL scoreboard: access with no expected item");
      end else begin
        it = sbq.pop_front();
        checks++;
        if (it.isRd) begin
          if (prdata !== it.exp) begin
            failures++;
            $display("FAIL %s: addr=%02h prdata=%08h expected=%08h", it.tag, paddr, prdata, it.exp);
          end
        end else if (pslverr !== 1'b0) begin
          failures++;
          $display("FAIL %s: addr=%02h pslverr=%0b expected=0", it.tag, paddr, pslverr);
        end
      end
    end
  end

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    failures++;
    $display("FAIL watchdog: run did not complete");
    report();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    rd(8'h20, 32'h0, "R1 status");
    rd(8'h04, 32'h0, "R1 mode");
    rd(8'h40, 32'h0, "R1 cs0");
    rd(8'h18, 32'h0, "R1 mask");
    rd(8'h1C, 32'h0, "R1 lock");

    // R3: writes with lock clear
    wr(8'h04, 32'h5A, "R3 write mode");
    rd(8'h04, 32'h5A, "R3 mode readback");
    wr(8'h44, 32'h1234, "R3 write cs1");
    rd(8'h44, 32'h1234, "R3 cs1 readback");
    rd(8'h20, 32'h0, "R3 no flag on legal write");

    // R2: blocked writes
    wr(8'h1C, 32'h1, "R3 lock write");
    rd(8'h1C, 32'h1, "R3 lock readback");
    wr(8'h04, 32'hFF, "R2 blocked write no error");
    rd(8'h04, 32'h5A, "R2 mode unchanged");
    rd(8'h20, 32'h0000_0401, "R2 status after blocked mode");
    rd(8'h20, 32'h0, "R8 status cleared by read");
    wr(8'h48, 32'h9999, "R2 blocked cs2");
    rd(8'h48, 32'h0, "R2 cs2 unchanged");
    rd(8'h20, 32'h0000_4801, "R2 status after blocked cs2");

    // R10: mask ports stay writable under lock
    wr(8'h10, 32'h5, "R10 enable");
    wr(8'h14, 32'h1, "R10 disable");
    rd(8'h18, 32'h4, "R10 mask readback");
    rd(8'h20, 32'h0, "R10 mask writes raise no flag");

    // R4: mode write while a chip select is active
    wr(8'h1C, 32'h0, "R3 unlock");
    setCs(4'b0010);
    wr(8'h04, 32'h33, "R4 mode write while busy");
    rd(8'h20, 32'h0000_0404, "R4 in-use status");
    rd(8'h04, 32'h33, "R4 write took effect");

    // R5: chip-select writes against activity
    wr(8'h40, 32'h1, "R5 cs0 write, cs1 active");
    rd(8'h20, 32'h0, "R5 other cs active no flag");
    wr(8'h44, 32'h22, "R5 cs1 write, cs1 active");
    rd(8'h20, 32'h0000_4404, "R5 in-use status cs1");
    setCs(4'b0000);

    // R6: software reset while locked
    wr(8'h1C, 32'h1, "R6 lock");
    wr(8'h00, 32'h1, "R6 soft reset locked");
    rd(8'h20, 32'h0000_0002, "R6 reset flag");
    rd(8'h04, 32'h0, "R6 mode cleared");
    rd(8'h18, 32'h0, "R6 mask cleared");
    rd(8'h44, 32'h0, "R6 cs1 cleared");

    // R7: reset flag cleared by writes
    wr(8'h00, 32'h1, "R7 soft reset");
    wr(8'h10, 32'h0, "R7 enable-port write");
    rd(8'h20, 32'h0, "R7 flag cleared by enable write");
    wr(8'h00, 32'h1, "R7 soft reset again");
    wr(8'h04, 32'h77, "R7 blocked mode write");
    rd(8'h20, 32'h0000_0401, "R7 bit1 cleared, bit0 set");

    // R8: accumulation of events
    setCs(4'b0001);
    wr(8'h40, 32'hAB, "R8 blocked busy cs0");
    rd(8'h20, 32'h0000_4005, "R8 blocked plus in-use");
    wr(8'h04, 32'h11, "R8 blocked busy mode");
    wr(8'h00, 32'h1, "R8 soft reset locked");
    rd(8'h20, 32'h0000_0407, "R8 all three flags");
    rd(8'h20, 32'h0, "R8 emptied");
    setCs(4'b0000);

    // R9: status write ignored
    wr(8'h04, 32'h1, "R9 blocked mode");
    wr(8'h20, 32'hFFFF_FFFF, "R9 status write");
    rd(8'h20, 32'h0000_0401, "R9 status unchanged by write");

    // R6: reset with lock clear, R3 chip-select write
    wr(8'h1C, 32'h0, "R6 unlock");
    wr(8'h00, 32'h1, "R6 soft reset unlocked");
    rd(8'h20, 32'h0, "R6 no flag when unlocked");
    wr(8'h4C, 32'hBEEF, "R3 write cs3");
    rd(8'h4C, 32'hBEEF, "R3 cs3 readback");

    repeat (4) @(posedge clk);
    if (sbq.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: %0d items left, expected 0", sbq.size());
    end
    report();
  end
endmodule